// File: doc/BRIEF.md
# Command Stream Method Decoder

The decoder takes a stream of 32-bit command words, as fetched from a command buffer, and turns it into individual method writes. Each write is a triple: a subchannel, a method address counted in words, and one 32-bit data value. Words come in on a valid/ready stream and triples leave on a second valid/ready stream. The output triple is held in a register.

A header word picks one of four kinds of command. An immediate header carries a short data value inside itself and yields exactly one write. The other three kinds are followed by a count of data words. An incrementing header steps the method address up by one for every data word. A non-incrementing header sends every data word to the same address. An increment-once header sends its first data word to the given address and every later data word to the address one above it.

A header with a zero count yields nothing, and the word after it is read as a header. A header with an unrecognised opcode is dropped and sets an error flag that only reset clears. Under output backpressure the pending triple stays unchanged, and no new word is taken until the output register can take its result.

Top module: `cmd_method_decoder`

## Requirements
- R1: After reset, out_valid is 0, err_flag is 0 and in_ready is 1.
- R2: A header whose bits [31:29] equal 4 (immediate) yields exactly one write. Its subchannel is bits [15:13], its method is bits [11:0] and its data is bits [28:16] zero-extended to 32 bits. The word after it is read as a header.
- R3: A header whose opcode is 1 (incrementing) and whose count in bits [28:16] is N > 0 takes the next N words as data. Write k (counting from 0) goes to method M+k modulo 4096, where M is bits [11:0].
- R4: A header whose opcode is 3 (non-incrementing) with count N > 0 sends all N following data words to method M.
- R5: A header whose opcode is 5 (increment-once) with count N > 0 sends its first data word to method M and every later data word to M+1 modulo 4096.
- R6: An immediate header and an incrementing header with count 1 followed by one data word produce identical triples when they carry the same subchannel, method and value.
- R7: A header of opcode 1, 3 or 5 with count 0 yields no write, and the next word is read as a header. Headers never produce a write themselves, except an immediate header.
- R8: A header with opcode 0, 2, 6 or 7 yields no write, is discarded, and sets err_flag. err_flag then stays at 1 until reset.
- R9: While out_valid is 1 and out_ready is 0, the triple stays unchanged and in_ready is 0.
- R10: Every write that a header's data words produce carries that header's subchannel field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 32 | Command word: header or data |
| out_valid | output | 1 | Method write valid |
| out_ready | input | 1 | Consumer takes the write |
| out_subch | output | 3 | Subchannel of the write |
| out_method | output | 12 | Method address in words |
| out_data | output | 32 | Data of the write |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
Assertions check the following on every cycle:
- the held triple and the blocked input under backpressure;
- the stickiness of the error flag;
- that a non-immediate header never yields a write;
- the immediate data path;
- the address step between consecutive writes of incrementing and non-incrementing bursts.

Only the bench's scenarios can show some behaviours. These are the full order and content of the writes across mixed header kinds, the increment-once address pattern, and the wrap of the address at 4095. They also include the equality of the immediate and the one-word incrementing forms, and the silent discard of zero-count and unknown headers inside a long random stream.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  // Header field layout
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 3;
  localparam int CNT_W   = 13;
  localparam int SUB_W   = 3;
  localparam int MTH_W   = 12;
  localparam int OPC_LSB = 29;
  localparam int CNT_LSB = 16;
  localparam int SUB_LSB = 13;
  localparam int MTH_LSB = 0;

  // Opcode values
  localparam logic [OPC_W-1:0] OPC_INCR   = 3'd1;
  localparam logic [OPC_W-1:0] OPC_NONINC = 3'd3;
  localparam logic [OPC_W-1:0] OPC_IMMD   = 3'd4;
  localparam logic [OPC_W-1:0] OPC_ONCE   = 3'd5;

  // How the method address moves after a data word
  typedef enum logic [1:0] {
    STEP_INCR = 2'd0,
    STEP_HOLD = 2'd1,
    STEP_ONCE = 2'd2
  } step_e;

  typedef struct packed {
    logic             known;
    logic             imm;
    step_e            step;
    logic [CNT_W-1:0] cnt;
    logic [SUB_W-1:0] sub;
    logic [MTH_W-1:0] mth;
  } hdr_t;
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_dec_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word,
  output hdr_t         hdr
);
  logic [OPC_W-1:0] opc;
  logic             unused_gap;

  assign opc        = word[OPC_LSB +: OPC_W];
  assign unused_gap = word[SUB_LSB-1];

  always_comb begin
    hdr.cnt   = word[CNT_LSB +: CNT_W];
    hdr.sub   = word[SUB_LSB +: SUB_W];
    hdr.mth   = word[MTH_LSB +: MTH_W];
    hdr.known = 1'b1;
    hdr.imm   = 1'b0;
    hdr.step  = STEP_INCR;
    case (opc)
      OPC_INCR:   hdr.step = STEP_INCR;
      OPC_NONINC: hdr.step = STEP_HOLD;
      OPC_ONCE:   hdr.step = STEP_ONCE;
      OPC_IMMD:   hdr.imm  = 1'b1;
      default:    hdr.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmd_addr_step.sv
module cmd_addr_step
  import cmd_dec_pkg::*;
#(
  parameter int AW = MTH_W
) (
  input  step_e         step,
  input  logic          first,
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    case (step)
      STEP_INCR: nxt = cur + ONE;
      STEP_ONCE: nxt = first ? cur + ONE : cur;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/cmd_out_stage.sv
module cmd_out_stage #(
  parameter int W = 47
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         can_load
);
  assign can_load = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dout <= din;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(dout)); // R9
  AST_LOAD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    load |-> can_load); // R9
endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
  import cmd_dec_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int SUBC_W = SUB_W,
  parameter int ADDR_W = MTH_W,
  parameter int LEN_W  = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SUBC_W-1:0] out_subch,
  output logic [ADDR_W-1:0] out_method,
  output logic [DATA_W-1:0] out_data,
  output logic              err_flag
);
  localparam int TRIPLE_W = SUBC_W + ADDR_W + DATA_W;

  hdr_t              hdr;
  logic [LEN_W-1:0]  rem_q;
  step_e             step_q;
  logic [ADDR_W-1:0] mth_q, mth_nxt;
  logic [SUBC_W-1:0] sub_q;
  logic              first_q, err_q;
  logic              fire, hdr_phase, load_imm, load_dat, load;
  logic [TRIPLE_W-1:0] din, dout;
  logic [DATA_W-1:0]   imm_data;

  cmd_hdr_decode #(.W(DATA_W)) u_dec (.word(in_word), .hdr(hdr));

  cmd_addr_step #(.AW(ADDR_W)) u_step (
    .step(step_q), .first(first_q), .cur(mth_q), .nxt(mth_nxt)
  );

  assign hdr_phase = (rem_q == '0);
  assign fire      = in_valid & in_ready;
  assign load_imm  = fire & hdr_phase & hdr.known & hdr.imm;
  assign load_dat  = fire & ~hdr_phase;
  assign load      = load_imm | load_dat;
  assign imm_data  = DATA_W'(hdr.cnt);
  assign din       = load_dat ? {sub_q, mth_q, in_word}
                              : {hdr.sub, hdr.mth, imm_data};

  cmd_out_stage #(.W(TRIPLE_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .din(din), .out_ready(out_ready),
    .out_valid(out_valid), .dout(dout), .can_load(in_ready)
  );

  assign out_subch  = dout[DATA_W+ADDR_W +: SUBC_W];
  assign out_method = dout[DATA_W +: ADDR_W];
  assign out_data   = dout[0 +: DATA_W];
  assign err_flag   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      step_q  <= STEP_INCR;
      mth_q   <= '0;
      sub_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (fire) begin
      if (hdr_phase) begin
        if (!hdr.known) begin
          err_q <= 1'b1;
        end else if (!hdr.imm && hdr.cnt != '0) begin
          rem_q   <= hdr.cnt;
          step_q  <= hdr.step;
          mth_q   <= hdr.mth;
          sub_q   <= hdr.sub;
          first_q <= 1'b1;
        end
      end else begin
        rem_q   <= rem_q - 1'b1;
        mth_q   <= mth_nxt;
        first_q <= 1'b0;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (rst)
    load_imm |=> out_valid && out_data == $past(imm_data)); // R2
  AST_HDR_SILENT: assert property (@(posedge clk) disable iff (rst)
    fire && hdr_phase && !hdr.imm |=> !out_valid); // R7
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (rst)
    load_dat && step_q == STEP_INCR && !first_q
    |=> out_method == $past(out_method) + ADDR_W'(1)); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    load_dat && step_q == STEP_HOLD && !first_q
    |=> out_method == $past(out_method)); // R4
endmodule

// File: tb/test_cmd_method_decoder.sv
module test_cmd_method_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLE_LIMIT = 150000;

  typedef struct {
    logic [2:0]  sub;
    logic [11:0] mth;
    logic [31:0] data;
    string       tag;
  } exp_t;

  typedef struct {
    logic [31:0] w;
    string       tag;
  } wrd_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_subch;
  logic [11:0] out_method;
  logic [31:0] out_data;
  logic        err_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit drv_done = 0;
  bit stim_ready = 0;
  bit mon_en = 0;

  exp_t exp_q[$];
  wrd_t wrd_q[$];

  // reference state
  int          m_rem = 0;
  int          m_op = 0;
  logic [11:0] m_mth = '0;
  logic [2:0]  m_sub = '0;
  bit          m_first = 0;
  bit          m_err = 0;
  string       m_tag = "";

  bit          prev_stall = 0;
  logic [46:0] prev_trip = '0;

  cmd_method_decoder i_cmd_method_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_subch(out_subch), .out_method(out_method), .out_data(out_data),
    .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] hw(int op, int cnt, int sub, int mth);
    return {op[2:0], cnt[12:0], sub[2:0], 1'b0, mth[11:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push_w(logic [31:0] w, string tag);
    wrd_t e;
    e.w = w;
    e.tag = tag;
    wrd_q.push_back(e);
  endtask

  task automatic push_exp(logic [2:0] s, logic [11:0] m, logic [31:0] d, string tag);
    exp_t e;
    e.sub = s;
    e.mth = m;
    e.data = d;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic model(wrd_t e);
    logic [31:0] w;
    int op, cnt;
    w = e.w;
    if (m_rem == 0) begin
      op  = int'(w[31:29]);
      cnt = int'(w[28:16]);
      if (op == 4) begin
        push_exp(w[15:13], w[11:0], {19'd0, w[28:16]}, (e.tag != "") ? e.tag : "R2");
      end else if (op == 1 || op == 3 || op == 5) begin
        if (cnt != 0) begin
          m_rem = cnt;
          m_op = op;
          m_mth = w[11:0];
          m_sub = w[15:13];
          m_first = 1;
          m_tag = e.tag;
        end
      end else begin
        m_err = 1;
      end
    end else begin
      push_exp(m_sub, m_mth, w, (m_tag != "") ? m_tag :
               (m_op == 1) ? "R3" : (m_op == 3) ? "R4" : "R5");
      m_rem--;
      if (m_op == 1 || (m_op == 5 && m_first)) m_mth = m_mth + 12'd1;
      m_first = 0;
    end
  endtask

  // monitor and cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      check(err_flag == m_err, "R8", "err_flag", 64'(err_flag), 64'(m_err));
      if (prev_stall) begin
        check(out_valid == 1'b1 && {out_subch, out_method, out_data} == prev_trip,
              "R9", "held triple", 64'({out_subch, out_method, out_data}), 64'(prev_trip));
      end
      if (out_valid && !out_ready) begin
        check(in_ready == 1'b0, "R9", "in_ready under stall", 64'(in_ready), 64'd0);
      end
      if (in_valid && in_ready) begin
        model(wrd_q[0]);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected write", 64'(out_method), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_subch == e.sub, (e.tag == "R10") ? "R10" : e.tag, "subchannel",
                64'(out_subch), 64'(e.sub));
          check(out_method == e.mth, e.tag, "method", 64'(out_method), 64'(e.mth));
          check(out_data == e.data, e.tag, "data", 64'(out_data), 64'(e.data));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_trip  = {out_subch, out_method, out_data};
    end
  end

  // consumer backpressure
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) out_ready = 1'b0;
      else if (cyc % 400 < 60) out_ready = ($urandom_range(0, 9) < 2);
      else out_ready = ($urandom_range(0, 9) < 7);
    end
  end

  // word driver
  initial begin
    bit took;
    wait (stim_ready);
    while (wrd_q.size() != 0) begin
      int gap;
      gap = $urandom_range(0, 3);
      @(posedge clk);
      #2;
      if (gap == 0) begin
        in_valid = 1'b0;
        @(posedge clk);
        #2;
      end
      in_word  = wrd_q[0].w;
      in_valid = 1'b1;
      took = 0;
      while (!took) begin
        @(negedge clk);
        took = in_ready;
        @(posedge clk);
        #2;
      end
      void'(wrd_q.pop_front());
      in_valid = 1'b0;
    end
    drv_done = 1;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(err_flag == 1'b0, "R1", "err_flag after reset", 64'(err_flag), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    mon_en = 1;

    // directed cases
    push_w(hw(4, 13'h1FFF, 5, 12'h7A1), "R2");
    push_w(hw(4, 13'h0042, 6, 12'h010), "R10");
    push_w(hw(1, 3, 1, 12'hFFE), "R3");
    for (int i = 0; i < 3; i++) push_w($urandom, "");
    push_w(hw(3, 4, 2, 12'h300), "R4");
    for (int i = 0; i < 4; i++) push_w($urandom, "");
    push_w(hw(5, 4, 3, 12'hFFF), "R5");
    for (int i = 0; i < 4; i++) push_w(32'hA000_0000 + i, "");
    push_w(hw(4, 13'h1ABC, 2, 12'h123), "R6");
    push_w(hw(1, 1, 2, 12'h123), "R6");
    push_w(32'h0000_1ABC, "");
    push_w(hw(1, 0, 4, 12'h055), "R7");
    push_w(hw(4, 13'h0007, 4, 12'h056), "R7");
    push_w(hw(5, 0, 1, 12'h001), "R7");
    push_w(hw(3, 0, 1, 12'h002), "R7");
    push_w(hw(4, 13'h0008, 0, 12'h003), "R7");
    push_w(hw(3, 2, 7, 12'h444), "R10");
    push_w(32'h1111_1111, "");
    push_w(32'h2222_2222, "");

    // random mix of all valid kinds
    for (int h = 0; h < 300; h++) begin
      int k, op, cnt;
      k = $urandom_range(0, 3);
      op = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 4 : 5;
      cnt = (op == 4) ? int'($urandom_range(0, 8191)) : int'($urandom_range(0, 5));
      push_w(hw(op, cnt, $urandom_range(0, 7),
                ($urandom_range(0, 3) == 0) ? 4093 + $urandom_range(0, 2) : $urandom_range(0, 4095)), "");
      if (op != 4) for (int d = 0; d < cnt; d++) push_w($urandom, "");
    end

    // unknown opcodes mixed with valid commands
    for (int h = 0; h < 40; h++) begin
      int bo;
      bo = (h % 4 == 0) ? 0 : (h % 4 == 1) ? 2 : (h % 4 == 2) ? 6 : 7;
      push_w(hw(bo, $urandom_range(1, 5), $urandom_range(0, 7), $urandom_range(0, 4095)), "R8");
      push_w(hw(1, 2, h % 8, 100 + h), "R8");
      push_w($urandom, "");
      push_w($urandom, "");
    end
    stim_ready = 1;

    while ((!drv_done || exp_q.size() != 0) && cyc < CYCLE_LIMIT) @(negedge clk);
    repeat (4) @(negedge clk);
    if (cyc >= CYCLE_LIMIT) check(1'b0, "R9", "watchdog expired", 64'(cyc), 64'(CYCLE_LIMIT));
    check(exp_q.size() == 0, "R7", "writes left over", 64'(exp_q.size()), 64'd0);
    check(err_flag == 1'b1, "R8", "err_flag sticky at end", 64'(err_flag), 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule